// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target on a two-wire serial bus that fronts a 2048-byte memory array. It receives already-synchronized copies of the clock line and the data line. It pulls the data line low through an open-drain output enable. It recognises bus START and STOP conditions and decodes a control byte that carries a device-type nibble, three chip-select bits and a direction bit. Three strap inputs set which of up to eight devices on a shared bus it answers as.

Three transfers are supported: a byte write, a random read and a sequential read. A byte write sends the control byte, two address bytes and one data byte, then a STOP. A random read loads the address the same way, then issues a repeated START and a read control byte. A sequential read keeps acknowledging data bytes, and it can walk the whole array in one transaction. An internal 11-bit address pointer steps by one after every completed byte read or byte write. It wraps from the top address back to zero. While the write-protect input is high, the array behaves as read-only memory.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. Either one releases `sda_oe`.
- R2: The control byte is sent MSB first. Bits [7:4] must be 1010. Bit 3 must equal `strap_i[2]`, bit 2 must equal the inverse of `strap_i[1]`, and bit 1 must equal `strap_i[0]`. Bit 0 selects the direction: 1 means read. On a match the target drives `sda_oe` high during the ninth clock. On a mismatch it leaves the line released and ignores the rest of the transaction.
- R3: In a write, the byte after the control byte supplies pointer bits [10:8] in its bits [2:0]. The byte after that supplies pointer bits [7:0]. The target acknowledges both bytes.
- R4: A data byte is stored at the pointer only when a STOP directly follows its acknowledged ninth clock. The pointer then advances by one. A repeated START in that position stores nothing.
- R5: While `wp_i` is high at the STOP, the data byte is still acknowledged but the array is left unchanged. Reads are unaffected by `wp_i`.
- R6: In a read, the target presents the byte at the pointer MSB first. It changes `sda_oe` only while the clock line is low.
- R7: When the controller acknowledges a read byte, the target sends the byte at the next address. When the controller does not acknowledge, the target releases the line until the next START. The pointer advances by one after every read byte.
- R8: The pointer wraps from 0x7FF to 0x000, both after a write and during a sequential read.
- R9: A START or STOP inside a data byte discards that byte. The array keeps its old contents.
- R10: After reset `sda_oe` is low and the pointer is 0x000. A read with no address phase returns the byte at the pointer. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| wp_i | input | 1 | Write protect: high blocks all array writes |
| strap_i | input | 3 | Chip-address straps [2:0] |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The hardest situations to reach are the abort cases. These are a START or STOP that lands part-way through a data byte, and a repeated START that comes right after a fully acknowledged data byte where a STOP would have committed it. The bench's bus-controller tasks send a chosen number of data bits and then issue the condition. A later read through the normal read path shows that the old byte is still in place. Pointer wrap is reached the same way: a write at the top address is followed by a read with no address phase.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int AW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int HW = AW - 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CTRL = 3'd1, S_AHI = 3'd2, S_ALO = 3'd3,
    S_WDAT = 3'd4, S_RDAT = 3'd5, S_WAIT = 3'd6
  } st_t;

  st_t st;
  logic          scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, wbuf;
  logic [AW-1:0] ptr;
  logic [HW-1:0] ahi;
  logic          wpend, rw, sel_ok, mack;
  logic [7:0]    mem [DEPTH];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire rx_st    = (st == S_CTRL) || (st == S_AHI) || (st == S_ALO) || (st == S_WDAT);
  wire active   = (st != S_IDLE) && (st != S_WAIT);
  wire commit   = stop_c && (st == S_WDAT) && wpend && (cnt == 4'd1);
  wire sel_now  = (sh[7:4] == DEV_TYPE) && (sh[3] == strap_i[2]) &&
                  (sh[2] != strap_i[1]) && (sh[1] == strap_i[0]);
  wire [AW-1:0] ptr_inc = ptr + 1'b1;
  wire [7:0] rd_cur = mem[ptr];
  wire [7:0] rd_nxt = mem[ptr_inc];

  always_ff @(posedge clk)
    if (commit && !wp_i) mem[ptr] <= wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt <= '0;
      sh <= '0;
      tx <= '0;
      wbuf <= '0;
      ptr <= '0;
      ahi <= '0;
      wpend <= 1'b0;
      rw <= 1'b0;
      sel_ok <= 1'b0;
      mack <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        st <= S_CTRL;
        cnt <= '0;
        sda_oe <= 1'b0;
        wpend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        cnt <= '0;
        sda_oe <= 1'b0;
        wpend <= 1'b0;
        if (commit) ptr <= ptr_inc;
      end else if (scl_rise && active) begin
        if (cnt < 4'd9) cnt <= cnt + 1'b1;
        if (rx_st && cnt < 4'd8) sh <= {sh[6:0], sda_i};
        if (st == S_RDAT && cnt == 4'd8) mack <= ~sda_i;
      end else if (scl_fall && active) begin
        if (rx_st && cnt == 4'd8) begin
          unique case (st)
            S_CTRL: begin
              sel_ok <= sel_now;
              rw <= sh[0];
              sda_oe <= sel_now;
            end
            S_AHI: begin
              ahi <= sh[HW-1:0];
              sda_oe <= 1'b1;
            end
            S_ALO: begin
              ptr <= {ahi, sh};
              sda_oe <= 1'b1;
            end
            default: begin
              wbuf <= sh;
              wpend <= 1'b0;
              sda_oe <= 1'b1;
            end
          endcase
        end else if (rx_st && cnt == 4'd9) begin
          cnt <= '0;
          sda_oe <= 1'b0;
          unique case (st)
            S_CTRL:
              if (!sel_ok) st <= S_WAIT;
              else if (rw) begin
                st <= S_RDAT;
                tx <= rd_cur;
                sda_oe <= ~rd_cur[7];
              end else st <= S_AHI;
            S_AHI: st <= S_ALO;
            S_ALO: st <= S_WDAT;
            default: wpend <= 1'b1;
          endcase
        end else if (st == S_RDAT) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) begin
            tx <= tx << 1;
            sda_oe <= ~tx[6];
          end else if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (cnt == 4'd9) begin
            ptr <= ptr_inc;
            cnt <= '0;
            if (mack) begin
              tx <= rd_nxt;
              sda_oe <= ~rd_nxt[7];
            end else begin
              st <= S_WAIT;
              sda_oe <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

module i2c_eeprom_target_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic [2:0]    st_v,
  input logic [AW-1:0] ptr_v
);
  // R6
  oe_rise_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_i));
  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && scl_i && $past(sda_i) && !sda_i) |=> !sda_oe);
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !sda_oe);
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ptr_v) && $past(st_v) != 3'd3) |-> ptr_v == $past(ptr_v) + 1'b1);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v == 3'd0) |-> !sda_oe);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .st_v(st), .ptr_v(ptr)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;
  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, wp = 0;
  logic [2:0] strap = 3'b010;
  logic sda_oe;
  wire sda_bus = sda_m & ~sda_oe;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_eeprom_target uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                         .wp_i(wp), .strap_i(strap), .sda_oe(sda_oe));

  localparam logic [7:0] CW = 8'hA0, CR = 8'hA1;
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h3C}, {11'h001, 8'hC5}, {11'h002, 8'h6B},
    {11'h123, 8'h9A}, {11'h400, 8'h01}, {11'h7FE, 8'hE7},
    {11'h7FF, 8'h7E}, {11'h2AA, 8'h55}, {11'h0FF, 8'hFF}};

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1; tick(2); scl_m = 1; tick(4); sda_m = 0; tick(4); scl_m = 0; tick(2);
  endtask
  task automatic i2c_stop;
    sda_m = 0; tick(2); scl_m = 1; tick(4); sda_m = 1; tick(4);
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; tick(2); scl_m = 1; tick(4); scl_m = 0; tick(2);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; tick(2); scl_m = 1; tick(2); b = sda_bus; tick(2); scl_m = 0; tick(2);
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask
  task automatic rd_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    send_bit(~ack);
  endtask
  task automatic set_addr(input logic [10:0] a, output logic ok);
    logic k0, k1, k2;
    i2c_start; wr_byte(CW, k0); wr_byte({5'b0, a[10:8]}, k1); wr_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask
  task automatic byte_write(input logic [10:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1;
    set_addr(a, k0); wr_byte(d, k1); i2c_stop;
    ok = k0 & k1;
  endtask
  task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
    logic k0, k1;
    set_addr(a, k0); i2c_start; wr_byte(CR, k1); rd_byte(1'b0, d); i2c_stop;
  endtask
  task automatic cur_read(output logic [7:0] d);
    logic k;
    i2c_start; wr_byte(CR, k); rd_byte(1'b0, d); i2c_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] d;
    tick(4);
    chk("R10 oe in reset", {15'b0, sda_oe}, 16'h0);
    rst_n = 1; tick(4);
    chk("R10 oe after reset", {15'b0, sda_oe}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      byte_write(VEC[i][18:8], VEC[i][7:0], ok);
      chk("R3 write acks", {15'b0, ok}, 16'h1);
    end
    chk("R1 released after stop", {15'b0, sda_oe}, 16'h0);
    for (int i = 0; i < NV; i++) begin
      rand_read(VEC[i][18:8], d);
      chk("R6 random read", {8'b0, d}, {8'b0, VEC[i][7:0]});
    end

    // R2 select mismatches
    i2c_start; wr_byte(8'hA4, k); i2c_stop;
    chk("R2 inverted strap bit mismatch nack", {15'b0, k}, 16'h0);
    i2c_start; wr_byte(8'hB0, k); i2c_stop;
    chk("R2 device type mismatch nack", {15'b0, k}, 16'h0);
    i2c_start; wr_byte(8'hA2, k); i2c_stop;
    chk("R2 low strap bit mismatch nack", {15'b0, k}, 16'h0);

    // R8 write wrap, R4 pointer advance
    byte_write(11'h7FF, 8'h7E, ok);
    cur_read(d);
    chk("R8 pointer wraps after write at top", {8'b0, d}, 16'h003C);

    // R7 sequential read across the wrap
    set_addr(11'h7FE, ok); i2c_start; wr_byte(CR, k);
    rd_byte(1'b1, d); chk("R7 seq byte 0", {8'b0, d}, 16'h00E7);
    rd_byte(1'b1, d); chk("R7 seq byte 1", {8'b0, d}, 16'h007E);
    rd_byte(1'b1, d); chk("R8 seq wraps to 0", {8'b0, d}, 16'h003C);
    rd_byte(1'b0, d); chk("R7 seq byte 3", {8'b0, d}, 16'h00C5);
    tick(2);
    chk("R7 released after nack", {15'b0, sda_oe}, 16'h0);
    i2c_stop;
    cur_read(d);
    chk("R7 pointer after sequential read", {8'b0, d}, 16'h006B);

    // R5 write protect
    wp = 1;
    byte_write(11'h123, 8'h11, ok);
    chk("R5 data acked under protect", {15'b0, ok}, 16'h1);
    rand_read(11'h400, d);
    chk("R5 read under protect", {8'b0, d}, 16'h0001);
    wp = 0;
    rand_read(11'h123, d);
    chk("R5 array unchanged", {8'b0, d}, 16'h009A);

    // R9 START inside data byte
    set_addr(11'h123, ok);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    i2c_start; wr_byte(CR, k); rd_byte(1'b0, d); i2c_stop;
    chk("R9 start mid byte discards", {8'b0, d}, 16'h009A);

    // R9 STOP inside data byte
    set_addr(11'h123, ok);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    i2c_stop;
    rand_read(11'h123, d);
    chk("R9 stop mid byte discards", {8'b0, d}, 16'h009A);

    // R4 repeated START after an acked data byte stores nothing
    set_addr(11'h123, ok); wr_byte(8'h77, k);
    chk("R4 data byte acked", {15'b0, k}, 16'h1);
    i2c_start; wr_byte(CR, k); rd_byte(1'b0, d); i2c_stop;
    chk("R4 no store without stop", {8'b0, d}, 16'h009A);

    // R10 reset mid-run: pointer to 0, array kept
    set_addr(11'h2AA, ok); i2c_stop;
    rst_n = 0; tick(3); rst_n = 1; tick(3);
    chk("R10 oe after second reset", {15'b0, sda_oe}, 16'h0);
    cur_read(d);
    chk("R10 pointer zero, array kept", {8'b0, d}, 16'h003C);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule